// File: doc/BRIEF.md
# External interrupt flag controller

This block holds one request flag for each of eight external interrupt pins. Every pin is brought into the clock domain by a short synchroniser. A two-bit sense setting per channel then decides what raises the flag: a low level, a falling edge, a rising edge, or either edge. Each flag drives a pending-request output that goes to the interrupt vectoring logic. The same flags form an 8-bit status word that software reads over a plain register bus.

Software cannot raise a flag and may only clear one. A write of 0 clears flag n only if an earlier read returned flag n as 1, and no new set event has happened since that read. Hardware can also clear a flag. An exception-processing acknowledge clears it, except in low-level mode while the pin is still low. A transfer-controller start strobe clears it when that transfer's keep-flag control input is 0. When a set condition and a clear land in the same cycle, the set wins, so no request is lost.

Top module: `ext_irq_flags`

## Requirements
- R1: During reset and afterwards until an event occurs, all eight flags are 0. Flag n is bit n of `flags`, and `irq_req` follows `flags` bit for bit.
- R2: With sense code 2'b00 (low level; the code for channel n sits at `sense_cfg[2n+1:2n]`), the flag sets while the synchronised pin is low. A pin driven low appears on the flag at the third rising clock edge.
- R3: With sense code 2'b01, only a high-to-low transition of the synchronised pin sets the flag. A rising transition leaves it at 0.
- R4: With sense code 2'b10, only a low-to-high transition sets the flag. A falling transition leaves it at 0.
- R5: With sense code 2'b11, both transitions set the flag.
- R6: A bus write never sets a flag. A written 0 to a flag that has not been read as 1 leaves it unchanged.
- R7: After a read with `bus_rd` that saw flag n = 1, a later write with `bus_wdata[n]` = 0 clears flag n at that write's clock edge. Bits written as 1 leave their flags unchanged.
- R8: In any edge mode (codes 01, 10, 11), `exc_ack[n]` clears flag n at the next clock edge.
- R9: In low-level mode, `exc_ack[n]` clears flag n only if the synchronised pin is high. If the pin is low, the flag stays 1.
- R10: `xfer_start[n]` clears flag n when `xfer_keep[n]` is 0, and has no effect when it is 1.
- R11: When a set event and a clear request for the same channel fall in the same cycle, the flag ends at 1.
- R12: A set event after a read disarms that read. A following write of 0 leaves the flag at 1 until the flag is read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous external request pins, bit n for channel n |
| sense_cfg | input | 16 | Sense code per channel, bits [2n+1:2n]: 00 low, 01 fall, 10 rise, 11 both |
| bus_rd | input | 1 | Status read strobe; arms the clear of every flag that reads 1 |
| bus_wr | input | 1 | Status write strobe |
| bus_wdata | input | 8 | Write data; a 0 in bit n requests a clear of flag n |
| exc_ack | input | 8 | Exception-processing acknowledge per channel |
| xfer_start | input | 8 | Transfer-controller start strobe per channel |
| xfer_keep | input | 8 | Per channel: 1 keeps the flag on a transfer start, 0 clears it |
| flags | output | 8 | Flag status word, also the read data |
| irq_req | output | 8 | Pending request per channel |

## Verification
A pin change driven just after a falling clock edge reaches the flag at the third rising edge: two synchroniser stages, then the flag register. The bench therefore waits exactly three rising edges and samples at the next falling edge. Bus writes, acknowledges and start strobes are held for one full cycle and act at the single rising edge inside that cycle, so their results are read at the falling edge that ends the cycle. The same-cycle set and clear case is timed so that the acknowledge covers the one cycle in which the synchronised transition is visible.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef struct packed {
        logic now;
        logic prev;
    } pin_hist_t;

    typedef struct packed {
        logic set;
        logic hw_clr;
        logic sw_clr;
    } flag_evt_t;

    function automatic logic detect_set(input sense_e mode, input pin_hist_t h);
        logic hit;
        case (mode)
            SENSE_LOW:  hit = ~h.now;
            SENSE_FALL: hit = h.prev & ~h.now;
            SENSE_RISE: hit = ~h.prev & h.now;
            default:    hit = h.prev ^ h.now;
        endcase
        return hit;
    endfunction

    function automatic logic ack_may_clear(input sense_e mode, input logic level);
        return (mode != SENSE_LOW) || level;
    endfunction

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin,
    input  sense_e mode,
    output logic   level,
    output logic   set_ev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    pin_hist_t     hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[LAST-1:0], pin};
            prev_q <= sync_q[LAST];
        end
    end

    always_comb begin
        hist.now  = sync_q[LAST];
        hist.prev = prev_q;
        level     = hist.now;
        set_ev    = detect_set(mode, hist);
    end

endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic hw_clr,
    input  logic rd_seen,
    input  logic wr_zero,
    output logic flag,
    output logic armed
);
    logic      flag_q;
    logic      armed_q;
    flag_evt_t evt;

    always_comb begin
        evt.set    = set_ev;
        evt.hw_clr = hw_clr;
        evt.sw_clr = wr_zero & armed_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (evt.set)
                flag_q <= 1'b1;
            else if (evt.hw_clr || evt.sw_clr)
                flag_q <= 1'b0;

            if (evt.set)
                armed_q <= 1'b0;
            else if (rd_seen && flag_q)
                armed_q <= 1'b1;
            else if (evt.hw_clr || evt.sw_clr)
                armed_q <= 1'b0;
        end
    end

    assign flag  = flag_q;
    assign armed = armed_q;

endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
    import ext_irq_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CFG_W      = 2 * NCH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   pin_in,
    input  logic [CFG_W-1:0] sense_cfg,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [NCH-1:0]   bus_wdata,
    input  logic [NCH-1:0]   exc_ack,
    input  logic [NCH-1:0]   xfer_start,
    input  logic [NCH-1:0]   xfer_keep,
    output logic [NCH-1:0]   flags,
    output logic [NCH-1:0]   irq_req
);
    logic [NCH-1:0] set_ev;
    logic [NCH-1:0] pin_sync;
    logic [NCH-1:0] armed;
    logic [NCH-1:0] hw_clr;
    logic [NCH-1:0] wr_zero;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        sense_e mode;
        assign mode = sense_e'(sense_cfg[2*n +: 2]);

        irq_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk    (clk),
            .rst    (rst),
            .pin    (pin_in[n]),
            .mode   (mode),
            .level  (pin_sync[n]),
            .set_ev (set_ev[n])
        );

        assign hw_clr[n] = (exc_ack[n] & ack_may_clear(mode, pin_sync[n]))
                         | (xfer_start[n] & ~xfer_keep[n]);
        assign wr_zero[n] = bus_wr & ~bus_wdata[n];

        irq_flag_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_ev  (set_ev[n]),
            .hw_clr  (hw_clr[n]),
            .rd_seen (bus_rd),
            .wr_zero (wr_zero[n]),
            .flag    (flags[n]),
            .armed   (armed[n])
        );
    end

    assign irq_req = flags;

endmodule

// File: rtl/ext_irq_flags_chk.sv
module ext_irq_flags_chk #(
    parameter int NCH = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [2*NCH-1:0]   sense_cfg,
    input logic               bus_wr,
    input logic [NCH-1:0]     exc_ack,
    input logic [NCH-1:0]     xfer_start,
    input logic [NCH-1:0]     xfer_keep,
    input logic [NCH-1:0]     flags,
    input logic [NCH-1:0]     set_ev,
    input logic [NCH-1:0]     pin_sync,
    input logic [NCH-1:0]     armed
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (flags == '0)); // R1

    AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (rst)
        1 |=> ((flags & ~$past(flags) & ~$past(set_ev)) == '0)); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1 |=> ((flags & $past(set_ev)) == $past(set_ev))); // R11

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        AST_LEVEL_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
            (sense_cfg[2*n +: 2] == 2'b00 && !pin_sync[n] && flags[n] && exc_ack[n])
            |=> flags[n]); // R9

        AST_UNARMED_KEEP: assert property (@(posedge clk) disable iff (rst)
            (flags[n] && !armed[n] && !exc_ack[n] && !xfer_start[n]) |=> flags[n]); // R6

        AST_KEEP_ON_XFER: assert property (@(posedge clk) disable iff (rst)
            (flags[n] && xfer_start[n] && xfer_keep[n] && !exc_ack[n] && !bus_wr)
            |=> flags[n]); // R10
    end

endmodule

bind ext_irq_flags ext_irq_flags_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sense_cfg  (sense_cfg),
    .bus_wr     (bus_wr),
    .exc_ack    (exc_ack),
    .xfer_start (xfer_start),
    .xfer_keep  (xfer_keep),
    .flags      (flags),
    .set_ev     (set_ev),
    .pin_sync   (pin_sync),
    .armed      (armed)
);

// File: tb/ext_irq_flags_test.sv
`timescale 1ns/1ps
module ext_irq_flags_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_in = 8'hFF;
    logic [15:0] sense_cfg = 16'h0000;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'hFF;
    logic [7:0]  exc_ack = 8'h00;
    logic [7:0]  xfer_start = 8'h00;
    logic [7:0]  xfer_keep = 8'h00;
    logic [7:0]  flags;
    logic [7:0]  irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_irq_flags uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .sense_cfg(sense_cfg),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .exc_ack(exc_ack), .xfer_start(xfer_start), .xfer_keep(xfer_keep),
        .flags(flags), .irq_req(irq_req)
    );

    // {mode[1:0], start level, final level, expected flag}
    localparam logic [4:0] VEC [0:7] = '{
        5'b00_1_0_1,   // R2 low level seen
        5'b00_1_1_0,   // R2 stays high
        5'b01_1_0_1,   // R3 falling
        5'b01_0_1_0,   // R3 rising ignored
        5'b10_0_1_1,   // R4 rising
        5'b10_1_0_0,   // R4 falling ignored
        5'b11_0_1_1,   // R5 rising
        5'b11_1_0_1    // R5 falling
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(input int c);
        repeat (c) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_pin(input int c, input logic v);
        @(negedge clk) pin_in[c] = v;
        settle(3);
    endtask

    task automatic do_read();
        @(negedge clk) bus_rd = 1'b1;
        @(negedge clk) bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk) begin bus_wr = 1'b1; bus_wdata = d; end
        @(negedge clk) begin bus_wr = 1'b0; bus_wdata = 8'hFF; end
    endtask

    task automatic pulse_ack(input int c);
        @(negedge clk) exc_ack[c] = 1'b1;
        @(negedge clk) exc_ack[c] = 1'b0;
    endtask

    task automatic pulse_xfer(input int c, input logic keep);
        @(negedge clk) begin xfer_start[c] = 1'b1; xfer_keep[c] = keep; end
        @(negedge clk) xfer_start[c] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset flags", flags, 8'h00);
        rst = 1'b0;
        settle(4);
        check("R1 idle flags", flags, 8'h00);

        // table walk: vector i on channel i
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) begin
                sense_cfg[2*i +: 2] = VEC[i][4:3];
                pin_in[i] = VEC[i][2];
            end
            settle(5);
            pulse_ack(i);
            check($sformatf("R8/R9 vector %0d cleared before stimulus", i), {7'b0, flags[i]}, 8'h00);
            drive_pin(i, VEC[i][1]);
            check($sformatf("R2-5 vector %0d mode %b", i, VEC[i][4:3]),
                  {7'b0, flags[i]}, {7'b0, VEC[i][0]});
            check($sformatf("R1 irq_req mirrors flags vector %0d", i), irq_req, flags);
        end

        // fresh start, all channels falling-edge, pins high
        @(negedge clk) begin rst = 1'b1; sense_cfg = 16'h5555; pin_in = 8'hFF; end
        settle(2);
        @(negedge clk) rst = 1'b0;
        settle(3);
        check("R1 flags after second reset", flags, 8'h00);

        // R6: writes without a prior read
        drive_pin(0, 1'b0);
        check("R3 channel 0 set", flags, 8'h01);
        do_write(8'h00);
        check("R6 unarmed write of 0", flags, 8'h01);
        do_write(8'hFF);
        check("R6 write of 1 sets nothing", flags, 8'h01);

        // R7: read then write 0
        do_read();
        do_write(8'hFE);
        check("R7 read then clear", flags, 8'h00);

        // R12: new set after read disarms
        drive_pin(1, 1'b0);
        do_read();
        drive_pin(1, 1'b1);
        drive_pin(1, 1'b0);
        do_write(8'h00);
        check("R12 write after re-set ignored", flags, 8'h02);
        do_read();
        do_write(8'h00);
        check("R7 cleared after new read", flags, 8'h00);

        // R8: acknowledge in edge mode
        drive_pin(2, 1'b0);
        pulse_ack(2);
        check("R8 edge-mode ack clears", flags, 8'h00);

        // R10: transfer start with keep input
        drive_pin(3, 1'b0);
        pulse_xfer(3, 1'b1);
        check("R10 keep=1 leaves flag", flags, 8'h08);
        pulse_xfer(3, 1'b0);
        check("R10 keep=0 clears flag", flags, 8'h00);

        // R11: set and ack in the same cycle (both-edge mode)
        @(negedge clk) sense_cfg[9:8] = 2'b11;
        drive_pin(4, 1'b0);
        check("R5 channel 4 set", flags, 8'h10);
        @(negedge clk) pin_in[4] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) exc_ack[4] = 1'b1;
        @(negedge clk) exc_ack[4] = 1'b0;
        check("R11 set beats ack", flags, 8'h10);
        pulse_ack(4);
        check("R8 ack clears after collision", flags, 8'h00);

        // R9: level mode ack depends on pin
        @(negedge clk) sense_cfg[11:10] = 2'b00;
        settle(2);
        check("R2 level mode pin high no set", flags, 8'h00);
        drive_pin(5, 1'b0);
        check("R2 level mode low sets", flags, 8'h20);
        pulse_ack(5);
        check("R9 ack with pin low keeps flag", flags, 8'h20);
        drive_pin(5, 1'b1);
        settle(1);
        check("R9 flag held after pin high", flags, 8'h20);
        pulse_ack(5);
        check("R9 ack with pin high clears", flags, 8'h00);

        finish_run();
    end

endmodule